// File: doc/BRIEF.md
# Source Operand Mode Decoder

This block turns the two-bit source addressing mode and the four-bit source register number of a 16-bit processor into the control a datapath needs to obtain its source operand. It reports whether the operand is a hardwired constant and gives that constant's value. It also reports whether an extension word follows the instruction, which base is added to that word, whether a data memory read is needed, and by how much the source register is advanced afterwards.

A byte/word flag sets the step size of the post-increment and the width of a constant. A small registered stage computes the incremented register value and a write enable, ready for the register file's write port. All results are registered, so they appear one clock after a decode request. The ALU, the memory and the fetch of the extension word stay outside the block.

Top module: `srcmode_decoder`

## Requirements
- R1: For an ordinary register (neither R0, R2 nor R3), the mode codes behave as follows. Mode 00 (register) requests nothing. Mode 01 (indexed) requests an extension word, base register and a memory read. Mode 10 (indirect) requests a memory read with no extension word and base none. Mode 11 (indirect with increment) requests a memory read and a post-increment. The base_sel codes are 0 none, 1 register, 2 PC and 3 zero.
- R2: Register R3 yields a constant in every mode: 0 in mode 00, 1 in mode 01, 2 in mode 10 and 0xFFFF in mode 11.
- R3: Register R2 yields the constant 4 in mode 10 and 8 in mode 11. In mode 00 it is an ordinary register operand with no constant.
- R4: Register R2 in mode 01 (absolute) requests an extension word and a memory read, with base_sel 3 (zero).
- R5: Register R0 in mode 01 (PC-relative) requests an extension word and a memory read, with base_sel 2 (PC).
- R6: Register R0 in mode 11 (immediate) requests an extension word, with base_sel 0, no memory read and no post-increment.
- R7: Post-increment is 1 when byte_op is 1 and 2 when byte_op is 0. One cycle after the request, wb_en is 1 and wb_data equals src_value plus that step, modulo 2^16. With no increment, wb_en is 0 and wb_data is 0.
- R8: When byte_op is 1, a constant is zero-extended from its low 8 bits, so 0xFFFF becomes 0x00FF.
- R9: A constant operand never requests a memory read, an extension word or an increment.
- R10: While rst_n is low, every output is 0.
- R11: Results appear on the clock edge after the request. One cycle after dec_valid is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode request this cycle |
| src_mode | input | 2 | Source addressing mode code |
| src_reg | input | 4 | Source register number |
| byte_op | input | 1 | 1 = byte operation, 0 = word |
| src_value | input | 16 | Current value of the source register |
| is_const | output | 1 | Operand is a hardwired constant |
| const_val | output | 16 | Constant value |
| need_ext | output | 1 | Extension word must be fetched |
| base_sel | output | 2 | Base added to extension word: 0 none, 1 register, 2 PC, 3 zero |
| mem_rd | output | 1 | Operand must be read from memory |
| inc_amt | output | 2 | Post-increment step for the source register |
| wb_en | output | 1 | Write incremented value to the register file |
| wb_data | output | 16 | Incremented register value |

## Verification
Every output, including the incremented write-back value, is due exactly one rising edge after its request is applied. The bench changes inputs on the falling edge, lets one rising edge capture them, and compares on the next falling edge. It never looks at the same edge that loads the registers. The idle case is checked the same way: the output is read one edge after dec_valid drops. The reset state is read while reset is still asserted.

// File: rtl/srcmode_pkg.sv
package srcmode_pkg;
   typedef enum logic [1:0] {
      MODE_REG = 2'd0,
      MODE_IDX = 2'd1,
      MODE_IND = 2'd2,
      MODE_INC = 2'd3
   } amode_t;

   typedef enum logic [1:0] {
      BASE_NONE = 2'd0,
      BASE_REG  = 2'd1,
      BASE_PC   = 2'd2,
      BASE_ZERO = 2'd3
   } base_t;
endpackage

// File: rtl/srcmode_cgen.sv
module srcmode_cgen #(
   parameter int DATA_W = 16,
   parameter int REG_W  = 4,
   parameter int SR_REG = 2,
   parameter int CG_REG = 3
) (
   input  logic [1:0]        mode,
   input  logic [REG_W-1:0]  rnum,
   input  logic              byte_op,
   output logic              hit,
   output logic [DATA_W-1:0] value
);
   import srcmode_pkg::*;
   localparam logic [REG_W-1:0] SR_R = SR_REG[REG_W-1:0];
   localparam logic [REG_W-1:0] CG_R = CG_REG[REG_W-1:0];
   localparam int BYTE_W = 8;

   logic [DATA_W-1:0] raw;

   always_comb begin
      hit = 1'b0;
      raw = '0;
      if (rnum == CG_R) begin
         hit = 1'b1;
         case (amode_t'(mode))
            MODE_REG: raw = '0;
            MODE_IDX: raw = DATA_W'(1);
            MODE_IND: raw = DATA_W'(2);
            default:  raw = '1;
         endcase
      end else if (rnum == SR_R) begin
         if (amode_t'(mode) == MODE_IND) begin
            hit = 1'b1;
            raw = DATA_W'(4);
         end else if (amode_t'(mode) == MODE_INC) begin
            hit = 1'b1;
            raw = DATA_W'(8);
         end
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      if (b < BYTE_W) begin : g_low
         assign value[b] = raw[b];
      end else begin : g_high
         assign value[b] = raw[b] & ~byte_op;
      end
   end
endmodule

// File: rtl/srcmode_addr.sv
module srcmode_addr #(
   parameter int REG_W   = 4,
   parameter int PC_REG  = 0,
   parameter int SR_REG  = 2,
   parameter bit BYTE_EN = 1'b1
) (
   input  logic             [1:0]       mode,
   input  logic             [REG_W-1:0] rnum,
   input  logic                         byte_op,
   input  logic                         cg_hit,
   output logic                         need_ext,
   output srcmode_pkg::base_t           base,
   output logic                         mem_rd,
   output logic             [1:0]       inc
);
   import srcmode_pkg::*;
   localparam logic [REG_W-1:0] PC_R = PC_REG[REG_W-1:0];
   localparam logic [REG_W-1:0] SR_R = SR_REG[REG_W-1:0];

   logic [1:0] step;

   if (BYTE_EN) begin : g_byte
      assign step = byte_op ? 2'd1 : 2'd2;
   end else begin : g_word
      assign step = 2'd2;
   end

   always_comb begin
      need_ext = 1'b0;
      base     = BASE_NONE;
      mem_rd   = 1'b0;
      inc      = 2'd0;
      if (!cg_hit) begin
         case (amode_t'(mode))
            MODE_REG: ;
            MODE_IDX: begin
               need_ext = 1'b1;
               mem_rd   = 1'b1;
               if (rnum == PC_R)      base = BASE_PC;
               else if (rnum == SR_R) base = BASE_ZERO;
               else                   base = BASE_REG;
            end
            MODE_IND: mem_rd = 1'b1;
            default: begin
               if (rnum == PC_R) begin
                  need_ext = 1'b1;
               end else begin
                  mem_rd = 1'b1;
                  inc    = step;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/srcmode_incr.sv
module srcmode_incr #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [DATA_W-1:0] src_value,
   input  logic [1:0]        inc,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_data
);
   logic bump;
   assign bump = valid && (inc != 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en   <= 1'b0;
         wb_data <= '0;
      end else begin
         wb_en   <= bump;
         wb_data <= bump ? src_value + DATA_W'(inc) : '0;
      end
   end

   // R7
   wb_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_data == $past(src_value) + DATA_W'($past(inc)));
endmodule

// File: rtl/srcmode_decoder.sv
module srcmode_decoder #(
   parameter int DATA_W  = 16,
   parameter int REG_W   = 4,
   parameter int PC_REG  = 0,
   parameter int SR_REG  = 2,
   parameter int CG_REG  = 3,
   parameter bit BYTE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid,
   input  logic [1:0]        src_mode,
   input  logic [REG_W-1:0]  src_reg,
   input  logic              byte_op,
   input  logic [DATA_W-1:0] src_value,
   output logic              is_const,
   output logic [DATA_W-1:0] const_val,
   output logic              need_ext,
   output logic [1:0]        base_sel,
   output logic              mem_rd,
   output logic [1:0]        inc_amt,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_data
);
   import srcmode_pkg::*;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (REG_W < 2 || PC_REG >= (1 << REG_W) || SR_REG >= (1 << REG_W) ||
       CG_REG >= (1 << REG_W)) begin : g_bad_reg
      $error("special register numbers must fit in REG_W bits");
   end

   logic              c_hit;
   logic [DATA_W-1:0] c_val;
   logic              a_ext;
   base_t             a_base;
   logic              a_mem;
   logic [1:0]        a_inc;

   srcmode_cgen #(.DATA_W(DATA_W), .REG_W(REG_W), .SR_REG(SR_REG),
                  .CG_REG(CG_REG)) u_cgen (
      .mode(src_mode), .rnum(src_reg), .byte_op(byte_op),
      .hit(c_hit), .value(c_val));

   srcmode_addr #(.REG_W(REG_W), .PC_REG(PC_REG), .SR_REG(SR_REG),
                  .BYTE_EN(BYTE_EN)) u_addr (
      .mode(src_mode), .rnum(src_reg), .byte_op(byte_op), .cg_hit(c_hit),
      .need_ext(a_ext), .base(a_base), .mem_rd(a_mem), .inc(a_inc));

   srcmode_incr #(.DATA_W(DATA_W)) u_incr (
      .clk(clk), .rst_n(rst_n), .valid(dec_valid), .src_value(src_value),
      .inc(a_inc), .wb_en(wb_en), .wb_data(wb_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_const  <= 1'b0;
         const_val <= '0;
         need_ext  <= 1'b0;
         base_sel  <= 2'd0;
         mem_rd    <= 1'b0;
         inc_amt   <= 2'd0;
      end else if (dec_valid) begin
         is_const  <= c_hit;
         const_val <= c_val;
         need_ext  <= a_ext;
         base_sel  <= a_base;
         mem_rd    <= a_mem;
         inc_amt   <= a_inc;
      end else begin
         is_const  <= 1'b0;
         const_val <= '0;
         need_ext  <= 1'b0;
         base_sel  <= 2'd0;
         mem_rd    <= 1'b0;
         inc_amt   <= 2'd0;
      end
   end

   // R9
   const_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_const |-> !mem_rd && !need_ext && inc_amt == 2'd0 && !wb_en);

   // R4
   zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_sel == 2'd3 |-> need_ext && mem_rd);

   // R6
   imm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (need_ext && !mem_rd) |-> base_sel == 2'd0 && !is_const && inc_amt == 2'd0);

   // R11
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> !is_const && !need_ext && !mem_rd && !wb_en && base_sel == 2'd0);

   // R7
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> inc_amt == ($past(byte_op) ? 2'd1 : 2'd2));
endmodule

// File: tb/srcmode_decoder_tb.sv
module srcmode_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_valid = 1'b0;
   logic [1:0]  src_mode = '0;
   logic [3:0]  src_reg = '0;
   logic        byte_op = 1'b0;
   logic [15:0] src_value = '0;
   logic        is_const, need_ext, mem_rd, wb_en;
   logic [15:0] const_val, wb_data;
   logic [1:0]  base_sel, inc_amt;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   srcmode_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .src_mode(src_mode),
      .src_reg(src_reg), .byte_op(byte_op), .src_value(src_value),
      .is_const(is_const), .const_val(const_val), .need_ext(need_ext),
      .base_sel(base_sel), .mem_rd(mem_rd), .inc_amt(inc_amt),
      .wb_en(wb_en), .wb_data(wb_data));

   // {mode, reg, byte, const, value, ext, base, mem, inc}
   localparam int NV = 20;
   localparam logic [29:0] VEC [NV] = '{
      {2'd0, 4'd5,  1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd1, 4'd5,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b1, 2'd0},
      {2'd2, 4'd5,  1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd0},
      {2'd3, 4'd5,  1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd2},
      {2'd3, 4'd5,  1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd1},
      {2'd0, 4'd3,  1'b0, 1'b1, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd1, 4'd3,  1'b0, 1'b1, 16'h0001, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd2, 4'd3,  1'b0, 1'b1, 16'h0002, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd3, 4'd3,  1'b0, 1'b1, 16'hFFFF, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd3, 4'd3,  1'b1, 1'b1, 16'h00FF, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd2, 4'd2,  1'b0, 1'b1, 16'h0004, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd3, 4'd2,  1'b0, 1'b1, 16'h0008, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd3, 4'd2,  1'b1, 1'b1, 16'h0008, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd0, 4'd2,  1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd1, 4'd2,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd3, 1'b1, 2'd0},
      {2'd1, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd2, 1'b1, 2'd0},
      {2'd3, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b0, 2'd0},
      {2'd0, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd1, 4'd3,  1'b1, 1'b1, 16'h0001, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd3, 4'd15, 1'b1, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd1}
   };

   function automatic string tag_of(logic [1:0] m, logic [3:0] r, logic b);
      if (r == 4'd3)                 return b ? "R8/R2" : "R2";
      if (r == 4'd2 && m >= 2'd2)    return "R3";
      if (r == 4'd2 && m == 2'd0)    return "R3";
      if (r == 4'd2)                 return "R4";
      if (r == 4'd0 && m == 2'd1)    return "R5";
      if (r == 4'd0 && m == 2'd3)    return "R6";
      if (m == 2'd3)                 return "R7";
      return "R1";
   endfunction

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic apply(logic v, logic [1:0] m, logic [3:0] r, logic b, logic [15:0] sv);
      @(negedge clk);
      dec_valid = v; src_mode = m; src_reg = r; byte_op = b; src_value = sv;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "is_const", 16'(is_const), 16'h0);
      chk("R10", "const_val", const_val, 16'h0);
      chk("R10", "flags", 16'({need_ext, base_sel, mem_rd, inc_amt, wb_en}), 16'h0);
      chk("R10", "wb_data", wb_data, 16'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [29:0] v;
         logic [15:0] sv, exp_wb;
         string t;
         v = VEC[i];
         sv = 16'h1230 + 16'(i * 3);
         t = tag_of(v[29:28], v[27:24], v[23]);
         apply(1'b1, v[29:28], v[27:24], v[23], sv);
         chk(t, "is_const", 16'(is_const), 16'(v[22]));
         if (v[22]) chk(t, "const_val", const_val, v[21:6]);
         chk(t, "need_ext", 16'(need_ext), 16'(v[5]));
         chk(t, "base_sel", 16'(base_sel), 16'(v[4:3]));
         chk(t, "mem_rd", 16'(mem_rd), 16'(v[2]));
         chk(t, "inc_amt", 16'(inc_amt), 16'(v[1:0]));
         // R7 / R9: write-back follows the increment
         exp_wb = (v[1:0] != 2'd0) ? sv + 16'(v[1:0]) : 16'h0;
         chk(v[22] ? "R9" : "R7", "wb_en", 16'(wb_en), 16'(v[1:0] != 2'd0));
         chk(v[22] ? "R9" : "R7", "wb_data", wb_data, exp_wb);
      end

      // R7: increment wraps modulo 2^16
      apply(1'b1, 2'd3, 4'd9, 1'b0, 16'hFFFF);
      chk("R7", "wrap wb_data", wb_data, 16'h0001);
      chk("R7", "wrap wb_en", 16'(wb_en), 16'h1);

      // R11: idle cycle clears every output, even with live inputs
      apply(1'b0, 2'd3, 4'd3, 1'b0, 16'h4444);
      chk("R11", "idle is_const", 16'(is_const), 16'h0);
      chk("R11", "idle const_val", const_val, 16'h0);
      chk("R11", "idle flags", 16'({need_ext, base_sel, mem_rd, inc_amt, wb_en}), 16'h0);
      chk("R11", "idle wb_data", wb_data, 16'h0);

      // R8: word -1 is full width, byte -1 is 0x00FF, back to back
      apply(1'b1, 2'd3, 4'd3, 1'b0, 16'h0);
      chk("R8", "word -1", const_val, 16'hFFFF);
      apply(1'b1, 2'd3, 4'd3, 1'b1, 16'h0);
      chk("R8", "byte -1", const_val, 16'h00FF);

      // R10: reset mid-run clears outputs
      apply(1'b1, 2'd3, 4'd7, 1'b0, 16'h0100);
      rst_n = 1'b0;
      #1;
      chk("R10", "reset wb_en", 16'(wb_en), 16'h0);
      chk("R10", "reset mem_rd", 16'(mem_rd), 16'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule